// File: doc/BRIEF.md
# Predistortion Table Training Sequencer

This controller fills a predistortion lookup table by direct measurement, with no adaptive loop. When told to start, it first moves the RF path selector so the power amplifier drives a dummy load. It then presents every table code, one at a time, as a pair of 4-bit I and Q symbols to the transmit DACs. For each code it collects a fixed number of demodulated I/Q samples from the feedback ADC path, averages each channel on its own, and writes the pair into the table at that code's address.

After the last code it routes the amplifier back to the antenna, waits for the path to settle, and pulses a done flag. Each change of the path selector and each new symbol is followed by a programmable settling wait, so the measured response is taken only after the analog chain has settled. A run may be started again at any later time to follow drift, and every run rewrites all entries.

The feedback sample input is a valid/ready stream. The sequencer raises ready only while it is gathering samples for the current symbol. A sample counts only on a cycle where valid and ready are both high. The source may drop valid for any number of cycles, and the gathering phase simply lasts longer. The table write port is a plain one-cycle strobe with no back-pressure.

Top module: `lut_train_seq`

## Requirements
- R1: One cycle after `start_i` is sampled in the idle state, `rf_to_load_o` is 1. It stays 1 through every sample acceptance and every table write of the run.
- R2: Each path-selector change and each new symbol is followed by a wait of `settle_cycles_i`+1 cycles. Counting the first cycle after the start edge as cycle 1, `adc_ready_o` first rises in cycle 2·S+3.
- R3: A run writes all 256 codes in ascending order. Address bits [7:4] carry the I code and bits [3:0] carry the Q code. During each write, `sym_i_o`/`sym_q_o` equal those two nibbles.
- R4: Exactly 32 samples are accepted per code. `adc_ready_o` is high only while gathering, and cycles without `adc_valid_i` lengthen the gathering phase without being counted.
- R5: Each written channel value is the signed floor of (sum of the 32 signed 12-bit samples)/32, formed separately for I and Q. Full-scale inputs (-2048, 2047) average without overflow.
- R6: The write of the last code is followed by a cycle that advances the code. From the next cycle `rf_to_load_o` is 0. After S+1 cycles on the antenna path, `done_o` is high for exactly one cycle. It is 1 in cycle S+3 after the last write.
- R7: `start_i` asserted during a run has no effect. The run keeps its address order and produces exactly 256 writes and one done pulse.
- R8: A run started after an earlier run has finished again writes all 256 entries from code 0.
- R9: During and right after reset, `rf_to_load_o`, `adc_ready_o`, `wr_en_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a training run (honoured only when idle) |
| settle_cycles_i | input | 16 | Settling wait S; each wait lasts S+1 cycles |
| rf_to_load_o | output | 1 | 1 = amplifier to dummy load, 0 = antenna |
| sym_i_o | output | 4 | I code of the current training symbol |
| sym_q_o | output | 4 | Q code of the current training symbol |
| adc_valid_i | input | 1 | Feedback sample valid |
| adc_ready_o | output | 1 | Sequencer accepts a feedback sample |
| adc_i_i | input | 12 | Signed demodulated I sample |
| adc_q_i | input | 12 | Signed demodulated Q sample |
| wr_en_o | output | 1 | Table write strobe |
| wr_addr_o | output | 8 | Table address {I code, Q code} |
| wr_i_o | output | 12 | Averaged signed I response |
| wr_q_o | output | 12 | Averaged signed Q response |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
Every result has a fixed due cycle, counted from the edge that samples start or from the edge of the last write. The selector moves one cycle after the start edge, and ready first appears in cycle 2·S+3. The path returns to the antenna two cycles after the final write, and done is due in cycle S+3 after it. The bench drives inputs and samples outputs on the falling edge and counts falling edges from the stimulus. Each check therefore compares an exact cycle number against these formulas, with no margin. The ADC model decides on each falling edge whether the next rising edge will carry a handshake, because ready is registered state and stays stable in between. From that it keeps its own per-code sum, which gives the expected average for the write strobe.

// File: rtl/lut_train_pkg.sv
package lut_train_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SW_WAIT,
    ST_SYM_WAIT,
    ST_GATHER,
    ST_COMMIT,
    ST_ADVANCE,
    ST_RELEASE
  } train_state_e;
endpackage

// File: rtl/lut_train_timer.sv
module lut_train_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q >= limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lut_train_avg.sv
module lut_train_avg #(
  parameter int SAMPLE_W = 12,
  parameter int LOG_AVG  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                add_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] avg_o
);
  localparam int ACC_W = SAMPLE_W + LOG_AVG;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] ext;

  assign ext   = ACC_W'($signed(sample_i));
  // arithmetic divide by 2**LOG_AVG: drop the low bits (floor)
  assign avg_o = acc_q[ACC_W-1:LOG_AVG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (add_i)  acc_q <= acc_q + ext;
  end
endmodule

// File: rtl/lut_train_ctrl.sv
module lut_train_ctrl
  import lut_train_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LOG_AVG = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              expired_i,
  input  logic              hs_i,
  output train_state_e      state_o,
  output logic              timer_clr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0]  ADDR_LAST  = '1;
  localparam logic [LOG_AVG-1:0] NSAMP_LAST = '1;

  train_state_e       state_q, state_d;
  logic [ADDR_W-1:0]  addr_q;
  logic [LOG_AVG-1:0] nsamp_q;
  logic               done_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (start_i)   state_d = ST_SW_WAIT;
      ST_SW_WAIT:  if (expired_i) state_d = ST_SYM_WAIT;
      ST_SYM_WAIT: if (expired_i) state_d = ST_GATHER;
      ST_GATHER:   if (hs_i && nsamp_q == NSAMP_LAST) state_d = ST_COMMIT;
      ST_COMMIT:   state_d = ST_ADVANCE;
      ST_ADVANCE:  state_d = (addr_q == ADDR_LAST) ? ST_RELEASE : ST_SYM_WAIT;
      ST_RELEASE:  if (expired_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign timer_clr_o = (state_d != state_q);
  assign state_o     = state_q;
  assign addr_o      = addr_q;
  assign done_o      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      nsamp_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_RELEASE) && (state_d == ST_IDLE);
      if (state_q == ST_IDLE && start_i)
        addr_q <= '0;
      else if (state_q == ST_ADVANCE && addr_q != ADDR_LAST)
        addr_q <= addr_q + 1'b1;
      if (state_q == ST_SYM_WAIT)
        nsamp_q <= '0;
      else if (state_q == ST_GATHER && hs_i)
        nsamp_q <= nsamp_q + 1'b1;
    end
  end
endmodule

// File: rtl/lut_train_seq.sv
module lut_train_seq
  import lut_train_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int SAMPLE_W = 12,
  parameter int LOG_AVG  = 5,
  parameter int SETTLE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [SETTLE_W-1:0]   settle_cycles_i,
  output logic                  rf_to_load_o,
  output logic [CODE_W-1:0]     sym_i_o,
  output logic [CODE_W-1:0]     sym_q_o,
  input  logic                  adc_valid_i,
  output logic                  adc_ready_o,
  input  logic [SAMPLE_W-1:0]   adc_i_i,
  input  logic [SAMPLE_W-1:0]   adc_q_i,
  output logic                  wr_en_o,
  output logic [2*CODE_W-1:0]   wr_addr_o,
  output logic [SAMPLE_W-1:0]   wr_i_o,
  output logic [SAMPLE_W-1:0]   wr_q_o,
  output logic                  done_o
);
  localparam int ADDR_W = 2 * CODE_W;
  localparam int NCH    = 2;

  train_state_e               state;
  logic                       timer_clr, expired, hs;
  logic [ADDR_W-1:0]          addr;
  logic [NCH-1:0][SAMPLE_W-1:0] smp, avg;

  assign hs          = adc_valid_i && adc_ready_o;
  assign adc_ready_o = (state == ST_GATHER);
  assign wr_en_o     = (state == ST_COMMIT);
  assign rf_to_load_o = (state != ST_IDLE) && (state != ST_RELEASE);
  assign sym_i_o     = addr[ADDR_W-1:CODE_W];
  assign sym_q_o     = addr[CODE_W-1:0];
  assign wr_addr_o   = addr;
  assign smp[0]      = adc_i_i;
  assign smp[1]      = adc_q_i;
  assign wr_i_o      = avg[0];
  assign wr_q_o      = avg[1];

  lut_train_ctrl #(.ADDR_W(ADDR_W), .LOG_AVG(LOG_AVG)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .expired_i(expired),
    .hs_i(hs), .state_o(state), .timer_clr_o(timer_clr), .addr_o(addr),
    .done_o(done_o)
  );

  lut_train_timer #(.CNT_W(SETTLE_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .clr_i(timer_clr),
    .limit_i(settle_cycles_i), .expired_o(expired)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    lut_train_avg #(.SAMPLE_W(SAMPLE_W), .LOG_AVG(LOG_AVG)) avg_i (
      .clk(clk), .rst_n(rst_n), .clr_i(state == ST_SYM_WAIT),
      .add_i(hs), .sample_i(smp[ch]), .avg_o(avg[ch])
    );
  end
endmodule

// File: rtl/lut_train_seq_chk.sv
module lut_train_seq_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rf_to_load_o,
  input logic              adc_ready_o,
  input logic              wr_en_o,
  input logic              done_o,
  input logic [CODE_W-1:0] sym_i_o,
  input logic [CODE_W-1:0] sym_q_o
);
  assert_write_on_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> rf_to_load_o);

  assert_ready_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ready_o |-> rf_to_load_o);

  assert_sym_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_ready_o && $past(adc_ready_o)) |-> ($stable(sym_i_o) && $stable(sym_q_o)));

  assert_write_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (!wr_en_o && !adc_ready_o));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_antenna_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rf_to_load_o);
endmodule

bind lut_train_seq lut_train_seq_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rf_to_load_o(rf_to_load_o),
  .adc_ready_o(adc_ready_o), .wr_en_o(wr_en_o), .done_o(done_o),
  .sym_i_o(sym_i_o), .sym_q_o(sym_q_o)
);

// File: tb/lut_train_seq_tb.sv
module lut_train_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] settle = '0;
  logic        rf, ready, wr_en, done, valid;
  logic [3:0]  sym_i, sym_q;
  logic [11:0] adc_i, adc_q, wr_i, wr_q;
  logic [7:0]  wr_addr;

  int tests = 0, fails = 0;
  int cyc = 0;
  // monitor / model state
  int mode = 0, cur_s = 0, exp_addr = 0, wr_count = 0, k = 0;
  int sum_i = 0, sum_q = 0, last_wr = -100, done_cnt = 0;
  bit gap = 0, finished = 0;

  always #2.5 clk = ~clk;

  lut_train_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .settle_cycles_i(settle),
    .rf_to_load_o(rf), .sym_i_o(sym_i), .sym_q_o(sym_q),
    .adc_valid_i(valid), .adc_ready_o(ready), .adc_i_i(adc_i), .adc_q_i(adc_q),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_i_o(wr_i), .wr_q_o(wr_q),
    .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int smp_i(int a, int n, int m);
    if (m == 1) return (a % 2 == 0) ? -2048 : 2047;
    return (a >> 4) * 250 - 1900 + (n * 37) % 61 - 30;
  endfunction

  function automatic int smp_q(int a, int n, int m);
    if (m == 1) return (a % 2 == 0) ? 2047 : -2048;
    return 1700 - (a & 15) * 230 + (n * 13) % 29 - 14;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // ADC model, table-write monitor and watchdog, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      summary();
    end
    if (rst_n) begin
      if (wr_en) begin
        chk(int'(wr_addr) == exp_addr, "R3 address order", wr_addr, exp_addr);
        chk({sym_i, sym_q} == wr_addr, "R3 symbol nibbles", {sym_i, sym_q}, wr_addr);
        chk(k == 32, "R4 samples per code", k, 32);
        chk($signed(wr_i) == (sum_i >>> 5), "R5 I average", $signed(wr_i), sum_i >>> 5);
        chk($signed(wr_q) == (sum_q >>> 5), "R5 Q average", $signed(wr_q), sum_q >>> 5);
        chk(rf == 1'b1, "R1 load path during write", rf, 1);
        exp_addr++; wr_count++; k = 0; sum_i = 0; sum_q = 0; last_wr = cyc;
      end
      if (wr_count == 256 && cyc == last_wr + 2)
        chk(rf == 1'b0, "R6 antenna after last write", rf, 0);
      if (done) begin
        done_cnt++;
        chk(cyc == last_wr + cur_s + 3, "R6 done timing", cyc - last_wr, cur_s + 3);
        chk(rf == 1'b0, "R6 antenna at done", rf, 0);
      end
    end
    if (ready && (!gap || cyc % 3 == 0)) begin
      int a;
      a = {sym_i, sym_q};
      valid = 1'b1;
      adc_i = 12'(smp_i(a, k, mode));
      adc_q = 12'(smp_q(a, k, mode));
      chk(rf == 1'b1, "R1 load path during sampling", rf, 1);
      sum_i += smp_i(a, k, mode);
      sum_q += smp_q(a, k, mode);
      k++;
    end else begin
      valid = 1'b0;
      adc_i = 12'h5A5;
      adc_q = 12'hA5A;
    end
  end

  task automatic run_training(input int s, input int m, input bit g,
                              input bit inject, input string tag);
    int n;
    @(negedge clk);
    settle = 16'(s); cur_s = s; mode = m; gap = g;
    exp_addr = 0; wr_count = 0; k = 0; sum_i = 0; sum_q = 0; done_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(rf == 1'b1, {tag, " R1 switch to load"}, rf, 1);
    chk(ready == 1'b0, {tag, " R2 no sample before settle"}, ready, 0);
    n = 1;
    while (!ready && n < 200000) begin
      @(negedge clk);
      n++;
    end
    chk(n == 2 * s + 3, {tag, " R2 first ready cycle"}, n, 2 * s + 3);
    while (!done && cyc < 150000) begin
      @(negedge clk);
      if (inject && wr_count == 100) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, {tag, " R6 done one cycle"}, done, 0);
    chk(wr_count == 256, {tag, " R3 all codes written"}, wr_count, 256);
    chk(done_cnt == 1, {tag, " R6 one done pulse"}, done_cnt, 1);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({rf, ready, wr_en, done} == 4'b0, "R9 outputs in reset", {rf, ready, wr_en, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rf, ready, wr_en, done} == 4'b0, "R9 outputs after reset", {rf, ready, wr_en, done}, 0);
  endtask

  task automatic test_sweep_basic();
    run_training(2, 0, 0, 0, "sweep");
  endtask

  task automatic test_gaps_fullscale();
    // R4 gaps in valid; R5 full-scale averages
    run_training(0, 1, 1, 0, "fullscale");
  endtask

  task automatic test_start_ignored();
    run_training(1, 0, 0, 1, "R7 start during run");
    chk(exp_addr == 256, "R7 order kept", exp_addr, 256);
  endtask

  task automatic test_restart();
    run_training(3, 0, 1, 0, "R8 first");
    run_training(0, 0, 0, 0, "R8 rerun");
    chk(exp_addr == 256, "R8 table rewritten", exp_addr, 256);
  endtask

  initial begin
    valid = 1'b0; adc_i = '0; adc_q = '0;
    test_reset();
    test_sweep_basic();
    test_gaps_fullscale();
    test_start_ignored();
    test_restart();
    repeat (4) @(negedge clk);
    summary();
  end
endmodule